// File: doc/BRIEF.md
# Boot-Time Strap Capture and Pad Role Sequencer

This block manages three shared pads that serve two roles in turn. At power-up each pad is an input whose resistor pull sets one configuration option. The block reads all three once, holds their drivers off for a settle window, and then turns each pad into a driven clock output. Pads A and B then carry the single-bit reference clock. Pad C carries either the 24 MHz or the 48 MHz source, and the captured pad A strap picks which one.

The captured options go to the rest of the chip: the 48/24 rate select, the spread-spectrum enable and the global output enable. When the global output enable is captured low, no output in the device may drive. The block also keeps its own three pad drivers off for as long as it runs. The reset input is asserted asynchronously and released through a two-stage synchroniser. `straps_valid` marks that the capture has happened, and `outputs_live` marks that the settle window has ended.

Top module: `strap_boot_seq`

## Requirements
- R1: While `rst_n` is low, `straps_valid`, `outputs_live`, all three `pad_*_oe`, all three `pad_*_out` and all three `cfg_*` outputs are 0. Assertion of `rst_n` takes effect at once, with no clock edge needed.
- R2: The pads are sampled on the third rising edge of `clk` after `rst_n` goes high. `straps_valid` rises at that edge and stays high until the next reset.
- R3: The pad A strap sets `cfg_rate_48`. A sampled 0 gives `cfg_rate_48` = 1 (48 MHz). A sampled 1 gives `cfg_rate_48` = 0 (24 MHz).
- R4: The pad B strap sets `cfg_ss_en`. A sampled 0 gives 1 (spread spectrum on). A sampled 1 gives 0.
- R5: The pad C strap sets `cfg_out_en`. A sampled 1 gives 1 (outputs active). A sampled 0 gives 0 (all outputs high-impedance).
- R6: After the capture edge, changes on `pad_a_in`, `pad_b_in` and `pad_c_in` have no effect on any `cfg_*` output.
- R7: `outputs_live` rises exactly WAIT_CYCLES rising edges after the capture edge and then stays high until reset. Before that, all `pad_*_oe` and all `pad_*_out` are 0.
- R8: Once `outputs_live` is high and `cfg_out_en` is 1, `pad_a_oe` and `pad_b_oe` are 1, and `pad_a_out` and `pad_b_out` follow `ref_clk_src`.
- R9: Once `outputs_live` is high, `pad_c_out` follows `clk48_src` when `cfg_rate_48` is 1 and follows `clk24_src` when it is 0. `pad_c_oe` equals `cfg_out_en`.
- R10: When `cfg_out_en` is 0, all three `pad_*_oe` stay 0 after the window ends, and `outputs_live` still rises on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the sampling and the window |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| ref_clk_src | input | 1 | Reference clock copy for pads A and B |
| clk24_src | input | 1 | 24 MHz source for pad C |
| clk48_src | input | 1 | 48 MHz source for pad C |
| pad_a_in | input | 1 | Pad A input side (rate strap) |
| pad_a_out | output | 1 | Pad A output data |
| pad_a_oe | output | 1 | Pad A driver enable |
| pad_b_in | input | 1 | Pad B input side (spread strap) |
| pad_b_out | output | 1 | Pad B output data |
| pad_b_oe | output | 1 | Pad B driver enable |
| pad_c_in | input | 1 | Pad C input side (output-enable strap) |
| pad_c_out | output | 1 | Pad C output data |
| pad_c_oe | output | 1 | Pad C driver enable |
| cfg_rate_48 | output | 1 | 1 = 48 MHz chosen for pad C |
| cfg_ss_en | output | 1 | Spread-spectrum enable for the chip |
| cfg_out_en | output | 1 | Global output enable for the chip |
| straps_valid | output | 1 | Straps have been captured |
| outputs_live | output | 1 | Settle window has ended |

## Verification
A wrong capture edge shows up as a `straps_valid` edge one cycle early or late, or as straps read from a pad that has already changed. Either is visible on the cycle right after the release sequence. A miscounted window moves the `outputs_live` rise and the enable rise by one or more cycles, so the bench checks the cycle before and the cycle of the expected edge. A wrong strap polarity or a wrong source mux shows up as soon as the pads go live: the bench steps the sources through patterns where the 24 MHz and 48 MHz inputs differ. A capture that re-samples later is caught by changing the pads after the capture edge and re-reading the `cfg_*` outputs.

// File: rtl/strap_boot_seq.sv
module strap_boot_seq #(
  parameter int WAIT_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk_src,
  input  logic clk24_src,
  input  logic clk48_src,
  input  logic pad_a_in,
  output logic pad_a_out,
  output logic pad_a_oe,
  input  logic pad_b_in,
  output logic pad_b_out,
  output logic pad_b_oe,
  input  logic pad_c_in,
  output logic pad_c_out,
  output logic pad_c_oe,
  output logic cfg_rate_48,
  output logic cfg_ss_en,
  output logic cfg_out_en,
  output logic straps_valid,
  output logic outputs_live
);
  localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [1:0]    rst_sync;
  logic [CW-1:0] cnt;
  logic          drive;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      straps_valid <= 1'b0;
      outputs_live <= 1'b0;
      cnt          <= '0;
      cfg_rate_48  <= 1'b0;
      cfg_ss_en    <= 1'b0;
      cfg_out_en   <= 1'b0;
    end else if (rst_sync[1]) begin
      if (!straps_valid) begin
        straps_valid <= 1'b1;
        cfg_rate_48  <= ~pad_a_in;
        cfg_ss_en    <= ~pad_b_in;
        cfg_out_en   <= pad_c_in;
      end else if (!outputs_live) begin
        if (cnt == LAST) outputs_live <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end
    end
  end

  assign drive     = outputs_live & cfg_out_en;
  assign pad_a_oe  = drive;
  assign pad_b_oe  = drive;
  assign pad_c_oe  = drive;
  assign pad_a_out = outputs_live & ref_clk_src;
  assign pad_b_out = outputs_live & ref_clk_src;
  assign pad_c_out = outputs_live & (cfg_rate_48 ? clk48_src : clk24_src);
endmodule

module strap_boot_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pad_a_oe,
  input logic pad_b_oe,
  input logic pad_c_oe,
  input logic cfg_rate_48,
  input logic cfg_ss_en,
  input logic cfg_out_en,
  input logic straps_valid,
  input logic outputs_live
);
  AST_OE_OFF_BEFORE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !outputs_live |-> !(pad_a_oe | pad_b_oe | pad_c_oe)); // R7
  AST_LIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    outputs_live |=> outputs_live); // R7
  AST_LIVE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    outputs_live |-> straps_valid); // R2
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid |=> straps_valid); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid |=> $stable({cfg_rate_48, cfg_ss_en, cfg_out_en})); // R6
  AST_GLOBAL_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_out_en |-> !(pad_a_oe | pad_b_oe | pad_c_oe)); // R10
endmodule

bind strap_boot_seq strap_boot_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .pad_a_oe(pad_a_oe), .pad_b_oe(pad_b_oe), .pad_c_oe(pad_c_oe),
  .cfg_rate_48(cfg_rate_48), .cfg_ss_en(cfg_ss_en), .cfg_out_en(cfg_out_en),
  .straps_valid(straps_valid), .outputs_live(outputs_live)
);

// File: tb/strap_boot_seq_tb.sv
module strap_boot_seq_tb_top;
  localparam int CLK_PER = 10;
  localparam int WAIT = 20;
  // {pad_a, pad_b, pad_c, exp_rate48, exp_ss, exp_oe}
  localparam logic [5:0] VEC [8] = '{6'b000_110, 6'b001_111, 6'b010_100, 6'b011_101,
                                     6'b100_010, 6'b101_011, 6'b110_000, 6'b111_001};

  logic clk = 0, rst_n = 0;
  logic ref_clk_src = 0, clk24_src = 0, clk48_src = 0;
  logic pa_i = 0, pb_i = 0, pc_i = 0;
  logic pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe, rate48, ss, oe, valid, live;
  int checks = 0, failures = 0;

  always #(CLK_PER/2) clk = ~clk;

  strap_boot_seq #(.WAIT_CYCLES(WAIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_clk_src(ref_clk_src), .clk24_src(clk24_src),
    .clk48_src(clk48_src), .pad_a_in(pa_i), .pad_a_out(pa_o), .pad_a_oe(pa_oe),
    .pad_b_in(pb_i), .pad_b_out(pb_o), .pad_b_oe(pb_oe), .pad_c_in(pc_i),
    .pad_c_out(pc_o), .pad_c_oe(pc_oe), .cfg_rate_48(rate48), .cfg_ss_en(ss),
    .cfg_out_en(oe), .straps_valid(valid), .outputs_live(live));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #(CLK_PER/4); end
  endtask

  initial begin
    #(CLK_PER * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1 reset state", {valid, live, pa_oe, pb_oe, pc_oe, rate48, ss, oe}, 8'h00);
    foreach (VEC[k]) begin
      logic [5:0] v = VEC[k];
      rst_n = 0; {pa_i, pb_i, pc_i} = v[5:3];
      ref_clk_src = 1; clk24_src = 1; clk48_src = 1;
      tick(2);
      chk("R1 outs in reset", {5'b0, pa_o, pb_o, pc_o}, 8'h00);
      rst_n = 1;
      tick(2);
      chk("R2 not yet sampled", {7'b0, valid}, 8'h00);
      tick(1);
      chk("R2 valid at capture edge", {7'b0, valid}, 8'h01);
      chk("R3 R4 R5 strap decode", {5'b0, rate48, ss, oe}, {5'b0, v[2:0]});
      {pa_i, pb_i, pc_i} = ~v[5:3];
      tick(2);
      chk("R6 pads ignored after capture", {5'b0, rate48, ss, oe}, {5'b0, v[2:0]});
      tick(WAIT - 3);
      chk("R7 window not yet over", {3'b0, live, pa_oe, pb_oe, pc_oe, pa_o | pb_o | pc_o}, 8'h00);
      tick(1);
      chk("R7 R10 live on time", {7'b0, live}, 8'h01);
      chk("R8 R9 R10 drivers", {5'b0, pa_oe, pb_oe, pc_oe}, {5'b0, {3{v[0]}}});
      for (int p = 0; p < 8; p++) begin
        {ref_clk_src, clk24_src, clk48_src} = p[2:0];
        #1;
        chk("R8 ref copy", {6'b0, pa_o, pb_o}, {6'b0, {2{p[2]}}});
        chk("R9 rate mux", {7'b0, pc_o}, {7'b0, v[2] ? p[0] : p[1]});
      end
      chk("R6 cfg still frozen", {5'b0, rate48, ss, oe}, {5'b0, v[2:0]});
    end
    #(CLK_PER/3);
    rst_n = 0;
    #1;
    chk("R1 async reset", {valid, live, pa_oe, pb_oe, pc_oe, rate48, ss, oe}, 8'h00);
    tick(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule